// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the access address for a synchronous SRAM front end that supports four-beat bursts. A load cycle captures the whole 18-bit external address and starts a fresh burst at beat zero. Each advance cycle then steps only the two least-significant address bits to the next beat. The upper bits stay fixed for the whole burst.

A static strap picks the order of the low bits. In linear order they count upward modulo four from the starting value. In interleaved order they are the starting value XOR-ed with the beat number. An active-low clock enable freezes all state, so a cycle can be stretched without ending the burst. A deselect cycle ends the burst. After that, an advance does nothing until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and `burst_active` is 0.
- R2: An enabled cycle (`cke_n`=0) with `chip_sel`=1 and `ld_adv`=0 is a load. After that edge, `addr_out` equals the sampled `addr_in`, `burst_active` is 1, and the beat number restarts at 0.
- R3: During an advance (`cke_n`=0, `chip_sel`=1, `ld_adv`=1, `burst_active`=1), `addr_out[17:2]` does not change.
- R4: With `order_il`=0 (linear), the low two bits of `addr_out` equal (start + beat) mod 4. Each advance moves the beat up by one, so the low bits step +1 mod 4.
- R5: With `order_il`=1 (interleaved), the low two bits of `addr_out` equal start XOR beat.
- R6: The beat number wraps from 3 to 0 and the burst keeps following the same sequence. After four advances the low bits are back at the start value.
- R7: While `cke_n`=1, `addr_out` and `burst_active` hold their values, provided the strap does not change.
- R8: An enabled cycle with `chip_sel`=0 clears `burst_active` and leaves the address state alone. An advance while `burst_active`=0 has no effect on `addr_out` or `burst_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_n | input | 1 | Active-low clock enable; high freezes all state |
| chip_sel | input | 1 | Select; low in an enabled cycle deselects and ends the burst |
| ld_adv | input | 1 | 0 loads a new address, 1 advances the burst |
| order_il | input | 1 | Burst-order strap: 0 linear, 1 interleaved |
| addr_in | input | 18 | External address sampled on a load |
| addr_out | output | 18 | Current access address |
| burst_active | output | 1 | A burst is in progress (set by a load, cleared by a deselect) |

## Verification
Assertions check four things on every cycle: a load captures the input address, the upper bits stay put on an advance, a linear advance steps the low bits by one, and both a frozen cycle and an idle advance leave the address unchanged. The interleaved XOR pattern, the wrap after the fourth beat and the reset values depend on the start address and the beat history, so only the bench scenarios show them. The bench runs directed bursts from several starting points in both orders and then a long seeded random mix of loads, advances, stalls and deselects, checked against its own model.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              chip_sel,
  input  logic              ld_adv,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              act_q;

  wire en       = !cke_n;
  wire do_load  = en && chip_sel && !ld_adv;
  wire do_adv   = en && chip_sel && ld_adv && act_q;
  wire do_desel = en && !chip_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      act_q  <= 1'b0;
    end else if (do_load) begin
      base_q <= addr_in;
      beat_q <= '0;
      act_q  <= 1'b1;
    end else if (do_adv) begin
      beat_q <= beat_q + 1'b1;
    end else if (do_desel) begin
      act_q <= 1'b0;
    end
  end

  wire [BEAT_W-1:0] start_lo = base_q[BEAT_W-1:0];
  wire [BEAT_W-1:0] low      = order_il ? (start_lo ^ beat_q) : (start_lo + beat_q);

  assign addr_out     = {base_q[ADDR_W-1:BEAT_W], low};
  assign burst_active = act_q;

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && chip_sel && !ld_adv) |=> (addr_out == $past(addr_in)) && burst_active);

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && chip_sel && ld_adv && burst_active)
      |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && chip_sel && ld_adv && burst_active && !order_il)
      |=> order_il || (addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(burst_active) && (!$stable(order_il) || $stable(addr_out)));

  assert_idle_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && chip_sel && ld_adv && !burst_active)
      |=> !burst_active && (!$stable(order_il) || $stable(addr_out)));

  assert_desel_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !chip_sel) |=> !burst_active);

endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b1, chip_sel = 1'b0, ld_adv = 1'b0, order_il = 1'b1;
  logic [17:0] addr_in = '0;
  logic [17:0] addr_out;
  logic burst_active;

  int checks = 0, failures = 0;
  logic [17:0] m_base = '0;
  logic [1:0]  m_beat = '0;
  logic        m_act = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .chip_sel(chip_sel),
    .ld_adv(ld_adv), .order_il(order_il), .addr_in(addr_in),
    .addr_out(addr_out), .burst_active(burst_active)
  );

  function automatic logic [17:0] exp_addr(logic [17:0] b, logic [1:0] k, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[17:2], lo};
  endfunction

  task automatic check(string tag, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic c_n, logic sel, logic la, logic il, logic [17:0] a);
    string tag;
    logic [17:0] prev_upper;
    logic adv_active;
    @(negedge clk);
    cke_n = c_n; chip_sel = sel; ld_adv = la; order_il = il; addr_in = a;
    prev_upper = exp_addr(m_base, m_beat, il);
    adv_active = 1'b0;
    if (c_n) tag = "R7 stall";
    else if (!sel) begin tag = "R8 deselect"; m_act = 1'b0; end
    else if (!la) begin tag = "R2 load"; m_base = a; m_beat = 2'd0; m_act = 1'b1; end
    else if (!m_act) tag = "R8 idle advance";
    else begin
      adv_active = 1'b1;
      tag = (m_beat == 2'd3) ? "R6 wrap" : (il ? "R5 interleaved" : "R4 linear");
      m_beat = m_beat + 2'd1;
    end
    @(posedge clk); #1;
    check(tag, {burst_active, addr_out}, {m_act, exp_addr(m_base, m_beat, il)});
    if (adv_active)
      check("R3 upper bits", {3'b0, addr_out[17:2]}, {3'b0, prev_upper[17:2]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", {burst_active, addr_out}, 19'd0);
    @(negedge clk); rst_n = 1'b1;
    // R8: advance before any load
    step(1'b0, 1'b1, 1'b1, 1'b1, 18'h3ffff);
    // R4, R6: linear burst from low bits 3, five advances
    step(1'b0, 1'b1, 1'b0, 1'b0, 18'h2abc7);
    repeat (5) step(1'b0, 1'b1, 1'b1, 1'b0, 18'h0);
    // R5, R6: interleaved burst from low bits 2
    step(1'b0, 1'b1, 1'b0, 1'b1, 18'h1234e);
    repeat (5) step(1'b0, 1'b1, 1'b1, 1'b1, 18'h3ffff);
    // R7: stall mid burst with changing inputs
    step(1'b1, 1'b1, 1'b0, 1'b1, 18'h00001);
    step(1'b1, 1'b0, 1'b1, 1'b1, 18'h00002);
    step(1'b0, 1'b1, 1'b1, 1'b1, 18'h0);
    // R8: deselect then advance
    step(1'b0, 1'b0, 1'b1, 1'b1, 18'h0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 18'h0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 18'h0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 18'h00001);
    step(1'b0, 1'b1, 1'b1, 1'b0, 18'h0);
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r < 4'd2, r != 4'd2, r > 4'd4, (i / 300) % 2 == 0, 18'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule